// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This combinational unit sits between a 32-bit processor datapath and a data memory that is one word wide. Memory is addressed in bytes, and four bytes are packed into each word. The memory is always accessed at the word that holds the addressed byte, so the unit turns the byte address into a word-aligned address by clearing its two low bits.

For a load, the unit takes the word read from memory and selects the addressed byte, halfword or whole word. It then widens the selection to 32 bits, either by copying its top bit (signed) or by filling with zeros (unsigned). For a store, it copies the store data into every matching lane and drives a per-byte write-enable mask. A run-time input chooses how lanes are numbered: either byte 0 is the least significant byte of the word, or byte 0 is the most significant. Any access that does not sit on its natural boundary raises a misalignment flag and blocks every write enable.

Access size encoding used throughout: 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 reserved.

Top module: `lsa_unit`

## Requirements
- R1: `o_mem_addr` equals `i_addr` with bits 1:0 forced to zero, for every size and mode.
- R2: Byte load: with `i_big_endian`=0, byte offset k (address bits 1:0) selects read bits 8k+7:8k; with `i_big_endian`=1 it selects bits 31-8k:24-8k.
- R3: Halfword load: with `i_big_endian`=0, offset 0 selects bits 15:0 and offset 2 selects bits 31:16; with `i_big_endian`=1, offset 0 selects bits 31:16 and offset 2 selects bits 15:0.
- R4: Word load returns the read word unchanged in both lane orders.
- R5: With `i_sign_ext`=1, result bits above a selected byte or halfword copy that item's top bit; with `i_sign_ext`=0 they are zero.
- R6: `o_misalign` is 1 for a halfword at an odd offset, for a word at a nonzero offset, and for the reserved size code. It is 0 for every byte access and for each naturally aligned access.
- R7: `o_byte_en` (bit i enables the byte at bits 8i+7:8i) is zero unless `i_store`=1 and the access is aligned. When enabled, it covers exactly the lanes that an R2/R3 load of the same address and size would read: one bit for a byte, two adjacent bits for a halfword, all four for a word.
- R8: `o_wr_word` holds `i_st_data[7:0]` in all four lanes for a byte store, `i_st_data[15:0]` in both halves for a halfword store, and `i_st_data` unchanged for a word store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_addr | input | 32 | Byte address of the access |
| i_size | input | 2 | Access size code (byte, half, word, reserved) |
| i_sign_ext | input | 1 | 1: signed load extension, 0: zero fill |
| i_store | input | 1 | 1: store access, enables byte writes |
| i_big_endian | input | 1 | 1: byte 0 is the most significant lane |
| i_rd_word | input | 32 | Word read from memory at the aligned address |
| i_st_data | input | 32 | Store data, right-justified |
| o_mem_addr | output | 32 | Word-aligned memory address |
| o_ld_value | output | 32 | Extended load result |
| o_byte_en | output | 4 | Per-lane write enables |
| o_wr_word | output | 32 | Lane-replicated write data |
| o_misalign | output | 1 | Misaligned or reserved-size access |

## Verification
The bench walks every byte offset under both lane orders, using a read word whose byte values and top bits all differ. A design that ignored the lane order, or reversed it for only one size, would therefore return a wrong byte or half. Signed and unsigned loads both use items with the top bit set and with it clear. A design that sign-extends from the wrong bit, or zero-fills a signed load, gives a wrong upper half. The bench tries each illegal offset of halfwords and words, plus the reserved size code, with `i_store` high. A design that leaks write enables on a fault, or flags byte accesses, is caught there. Store enables are compared against the lane each load selects, which exposes an enable mask that is mirrored or shifted one lane off.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } size_e;

   localparam int BYTE_W = 8;

   // lane-order variants selectable at elaboration
   localparam int ORDER_RUNTIME = 0;
   localparam int ORDER_LITTLE  = 1;
   localparam int ORDER_BIG     = 2;

   function automatic int size_bytes(size_e s, int lanes);
      case (s)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         default: return lanes;
      endcase
   endfunction

endpackage

// File: rtl/lsa_align_chk.sv
module lsa_align_chk
   import lsa_pkg::*;
#(
   parameter int OFS_W = 2
) (
   input  logic [OFS_W-1:0] ofs,
   input  size_e            size,
   output logic             fault
);

   always_comb begin
      case (size)
         SZ_BYTE: fault = 1'b0;
         SZ_HALF: fault = ofs[0];
         SZ_WORD: fault = |ofs;
         default: fault = 1'b1;
      endcase
   end

endmodule

// File: rtl/lsa_lane_map.sv
module lsa_lane_map
   import lsa_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int ORDER_MODE = ORDER_RUNTIME,
   localparam int OFS_W     = $clog2(LANES)
) (
   input  logic [OFS_W-1:0] ofs,
   input  size_e            size,
   input  logic             big,
   output logic [OFS_W-1:0] lane
);

   logic [OFS_W:0] span;
   logic [OFS_W:0] mirrored;
   logic           use_big;

   always_comb begin
      span     = (OFS_W+1)'(size_bytes(size, LANES));
      mirrored = (OFS_W+1)'(LANES) - span - {1'b0, ofs};
   end

   generate
      if (ORDER_MODE == ORDER_LITTLE) begin : g_little
         assign use_big = 1'b0;
      end else if (ORDER_MODE == ORDER_BIG) begin : g_big
         assign use_big = 1'b1;
      end else begin : g_runtime
         assign use_big = big;
      end
   endgenerate

   assign lane = use_big ? mirrored[OFS_W-1:0] : ofs;

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
   import lsa_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / BYTE_W,
   localparam int OFS_W = $clog2(LANES),
   localparam int HALF_W = 2 * BYTE_W
) (
   input  logic [DATA_W-1:0] rd_word,
   input  logic [OFS_W-1:0]  lane,
   input  size_e             size,
   input  logic              sign_ext,
   output logic [DATA_W-1:0] value
);

   logic [DATA_W-1:0] shifted;
   logic [BYTE_W-1:0] b_item;
   logic [HALF_W-1:0] h_item;
   logic              b_fill;
   logic              h_fill;

   always_comb begin
      shifted = rd_word >> (BYTE_W * int'(lane));
      b_item  = shifted[BYTE_W-1:0];
      h_item  = shifted[HALF_W-1:0];
      b_fill  = sign_ext & b_item[BYTE_W-1];
      h_fill  = sign_ext & h_item[HALF_W-1];
      case (size)
         SZ_BYTE: value = {{(DATA_W-BYTE_W){b_fill}}, b_item};
         SZ_HALF: value = {{(DATA_W-HALF_W){h_fill}}, h_item};
         default: value = rd_word;
      endcase
   end

   always_comb begin
      // R5
      if (size == SZ_BYTE && !sign_ext) begin
         unsigned_fill_chk: assert (value[DATA_W-1:BYTE_W] == '0)
            else $error("unsigned byte load has nonzero upper bits");
      end
   end

endmodule

// File: rtl/lsa_store_pack.sv
module lsa_store_pack
   import lsa_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / BYTE_W,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] st_data,
   input  logic [OFS_W-1:0]  lane,
   input  size_e             size,
   input  logic              write_ok,
   output logic [LANES-1:0]  byte_en,
   output logic [DATA_W-1:0] wr_word
);

   logic [LANES-1:0] base_mask;

   always_comb begin
      case (size)
         SZ_BYTE: base_mask = LANES'(1);
         SZ_HALF: base_mask = LANES'(3);
         default: base_mask = '1;
      endcase
      byte_en = write_ok ? (base_mask << lane) : '0;
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         always_comb begin
            case (size)
               SZ_BYTE: wr_word[BYTE_W*i +: BYTE_W] = st_data[BYTE_W-1:0];
               SZ_HALF: wr_word[BYTE_W*i +: BYTE_W] = st_data[BYTE_W*(i%2) +: BYTE_W];
               default: wr_word[BYTE_W*i +: BYTE_W] = st_data[BYTE_W*i +: BYTE_W];
            endcase
         end
      end
   endgenerate

   always_comb begin
      // R8
      if (size == SZ_BYTE) begin
         byte_repl_chk: assert (wr_word[DATA_W-1:DATA_W-BYTE_W] == st_data[BYTE_W-1:0])
            else $error("byte store not replicated into top lane");
      end
   end

endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
   import lsa_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int ORDER_MODE = ORDER_RUNTIME,
   localparam int LANES     = DATA_W / BYTE_W,
   localparam int OFS_W     = $clog2(LANES)
) (
   input  logic [ADDR_W-1:0] i_addr,
   input  logic [1:0]        i_size,
   input  logic              i_sign_ext,
   input  logic              i_store,
   input  logic              i_big_endian,
   input  logic [DATA_W-1:0] i_rd_word,
   input  logic [DATA_W-1:0] i_st_data,
   output logic [ADDR_W-1:0] o_mem_addr,
   output logic [DATA_W-1:0] o_ld_value,
   output logic [LANES-1:0]  o_byte_en,
   output logic [DATA_W-1:0] o_wr_word,
   output logic              o_misalign
);

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("lsa_unit: DATA_W must be 32");
      end
      if (ADDR_W <= OFS_W) begin : g_bad_addr_w
         $error("lsa_unit: ADDR_W too narrow");
      end
      if (ORDER_MODE < ORDER_RUNTIME || ORDER_MODE > ORDER_BIG) begin : g_bad_order
         $error("lsa_unit: unknown ORDER_MODE");
      end
   endgenerate

   size_e            size;
   logic [OFS_W-1:0] ofs;
   logic [OFS_W-1:0] lane;
   logic             fault;

   assign size = size_e'(i_size);
   assign ofs  = i_addr[OFS_W-1:0];

   assign o_mem_addr = {i_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
   assign o_misalign = fault;

   lsa_align_chk #(.OFS_W(OFS_W)) u_align (
      .ofs   (ofs),
      .size  (size),
      .fault (fault)
   );

   lsa_lane_map #(.LANES(LANES), .ORDER_MODE(ORDER_MODE)) u_map (
      .ofs  (ofs),
      .size (size),
      .big  (i_big_endian),
      .lane (lane)
   );

   lsa_load_extract #(.DATA_W(DATA_W)) u_load (
      .rd_word  (i_rd_word),
      .lane     (lane),
      .size     (size),
      .sign_ext (i_sign_ext),
      .value    (o_ld_value)
   );

   lsa_store_pack #(.DATA_W(DATA_W)) u_store (
      .st_data  (i_st_data),
      .lane     (lane),
      .size     (size),
      .write_ok (i_store & ~fault),
      .byte_en  (o_byte_en),
      .wr_word  (o_wr_word)
   );

   always_comb begin
      // R7
      if (o_misalign) begin
         fault_blocks_we_chk: assert (o_byte_en == '0)
            else $error("write enables active on misaligned access");
      end
      // R7
      if (i_store && !o_misalign) begin
         we_width_chk: assert ($countones(o_byte_en) == size_bytes(size, LANES))
            else $error("write enable count does not match access size");
      end
      // R4
      if (size == SZ_WORD) begin
         word_pass_chk: assert (o_ld_value == i_rd_word)
            else $error("word load altered the read word");
      end
      // R6
      if (size == SZ_BYTE) begin
         byte_never_faults_chk: assert (!o_misalign)
            else $error("byte access flagged as misaligned");
      end
   end

endmodule

// File: tb/lsa_unit_bench.sv
module lsa_unit_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] i_addr = '0;
   logic [1:0]  i_size = '0;
   logic        i_sign_ext = 1'b0;
   logic        i_store = 1'b0;
   logic        i_big_endian = 1'b0;
   logic [31:0] i_rd_word = '0;
   logic [31:0] i_st_data = '0;
   logic [31:0] o_mem_addr;
   logic [31:0] o_ld_value;
   logic [3:0]  o_byte_en;
   logic [31:0] o_wr_word;
   logic        o_misalign;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   lsa_unit u_lsa_unit (
      .i_addr(i_addr), .i_size(i_size), .i_sign_ext(i_sign_ext),
      .i_store(i_store), .i_big_endian(i_big_endian),
      .i_rd_word(i_rd_word), .i_st_data(i_st_data),
      .o_mem_addr(o_mem_addr), .o_ld_value(o_ld_value),
      .o_byte_en(o_byte_en), .o_wr_word(o_wr_word), .o_misalign(o_misalign)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (addr %h size %0d big %0b)",
                  req, act, exp, i_addr, i_size, i_big_endian);
      end
   endtask

   task automatic apply(logic [31:0] a, logic [1:0] s, logic sx, logic st, logic be);
      @(negedge clk);
      i_addr = a; i_size = s; i_sign_ext = sx; i_store = st; i_big_endian = be;
      #1;
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      chk("R1 reset", o_mem_addr, 32'h0);
      chk("R2 reset", o_ld_value, 32'h0);
      chk("R7 reset", {28'h0, o_byte_en}, 32'h0);
      chk("R6 reset", {31'h0, o_misalign}, 32'h0);
   endtask

   task automatic t_addr_align();
      i_rd_word = 32'h0;
      for (int k = 0; k < 4; k++) begin
         apply(32'h1234_5670 + 32'(k), 2'b00, 1'b0, 1'b0, 1'b0);
         chk("R1", o_mem_addr, 32'h1234_5670);
      end
      apply(32'hFFFF_FFFF, 2'b10, 1'b0, 1'b0, 1'b1);
      chk("R1", o_mem_addr, 32'hFFFF_FFFC);
   endtask

   task automatic t_byte_loads();
      i_rd_word = 32'h8A7F_C215;
      for (int be = 0; be < 2; be++)
         for (int sx = 0; sx < 2; sx++)
            for (int k = 0; k < 4; k++) begin
               logic [7:0] b;
               logic [31:0] exp;
               b = (be == 1) ? i_rd_word[8*(3-k) +: 8] : i_rd_word[8*k +: 8];
               exp = {24'h0, b};
               if (sx == 1 && b[7]) exp[31:8] = 24'hFF_FFFF;
               apply(32'h0000_0100 + 32'(k), 2'b00, sx[0], 1'b0, be[0]);
               chk(sx == 1 ? "R2 R5 signed byte" : "R2 R5 unsigned byte", o_ld_value, exp);
               chk("R6 byte", {31'h0, o_misalign}, 32'h0);
            end
   endtask

   task automatic t_half_loads();
      logic [31:0] words [2];
      words[0] = 32'h9ABC_7123;
      words[1] = 32'h4567_F001;
      for (int w = 0; w < 2; w++) begin
         i_rd_word = words[w];
         for (int be = 0; be < 2; be++)
            for (int sx = 0; sx < 2; sx++)
               for (int k = 0; k < 4; k += 2) begin
                  logic [15:0] h;
                  logic [31:0] exp;
                  h = (be == 1) ? i_rd_word[16*(1-k/2) +: 16] : i_rd_word[16*(k/2) +: 16];
                  exp = {16'h0, h};
                  if (sx == 1 && h[15]) exp[31:16] = 16'hFFFF;
                  apply(32'h0000_0200 + 32'(k), 2'b01, sx[0], 1'b0, be[0]);
                  chk("R3 R5 half load", o_ld_value, exp);
                  chk("R6 half aligned", {31'h0, o_misalign}, 32'h0);
               end
      end
   endtask

   task automatic t_word_loads();
      i_rd_word = 32'hDEAD_0B7E;
      for (int be = 0; be < 2; be++) begin
         apply(32'h0000_0300, 2'b10, 1'b1, 1'b0, be[0]);
         chk("R4 word load", o_ld_value, 32'hDEAD_0B7E);
         chk("R6 word aligned", {31'h0, o_misalign}, 32'h0);
      end
   endtask

   task automatic t_stores();
      i_st_data = 32'hCAFE_5AA5;
      for (int be = 0; be < 2; be++) begin
         for (int k = 0; k < 4; k++) begin
            logic [3:0] e;
            e = (be == 1) ? 4'(1 << (3 - k)) : 4'(1 << k);
            apply(32'h0000_0400 + 32'(k), 2'b00, 1'b0, 1'b1, be[0]);
            chk("R7 byte enable", {28'h0, o_byte_en}, {28'h0, e});
            chk("R8 byte data", o_wr_word, 32'hA5A5_A5A5);
         end
         for (int k = 0; k < 4; k += 2) begin
            logic [3:0] e;
            e = (be == 1) ? ((k == 0) ? 4'b1100 : 4'b0011) : ((k == 0) ? 4'b0011 : 4'b1100);
            apply(32'h0000_0400 + 32'(k), 2'b01, 1'b0, 1'b1, be[0]);
            chk("R7 half enable", {28'h0, o_byte_en}, {28'h0, e});
            chk("R8 half data", o_wr_word, 32'h5AA5_5AA5);
         end
         apply(32'h0000_0400, 2'b10, 1'b0, 1'b1, be[0]);
         chk("R7 word enable", {28'h0, o_byte_en}, 32'hF);
         chk("R8 word data", o_wr_word, 32'hCAFE_5AA5);
         apply(32'h0000_0400, 2'b10, 1'b0, 1'b0, be[0]);
         chk("R7 load no enable", {28'h0, o_byte_en}, 32'h0);
      end
   endtask

   task automatic t_misalign();
      for (int be = 0; be < 2; be++) begin
         for (int k = 1; k < 4; k += 2) begin
            apply(32'h0000_0500 + 32'(k), 2'b01, 1'b0, 1'b1, be[0]);
            chk("R6 odd half", {31'h0, o_misalign}, 32'h1);
            chk("R7 odd half enable", {28'h0, o_byte_en}, 32'h0);
         end
         for (int k = 1; k < 4; k++) begin
            apply(32'h0000_0500 + 32'(k), 2'b10, 1'b0, 1'b1, be[0]);
            chk("R6 unaligned word", {31'h0, o_misalign}, 32'h1);
            chk("R7 unaligned word enable", {28'h0, o_byte_en}, 32'h0);
         end
         apply(32'h0000_0500, 2'b11, 1'b0, 1'b1, be[0]);
         chk("R6 reserved size", {31'h0, o_misalign}, 32'h1);
         chk("R7 reserved size enable", {28'h0, o_byte_en}, 32'h0);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      rst = 1'b0;
      t_reset_state();
      t_addr_align();
      t_byte_loads();
      t_half_loads();
      t_word_loads();
      t_stores();
      t_misalign();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule